// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small microcontroller core and turns a set of request pulses into one interrupt request with a 16-bit vector address. Every latched source has a pending bit. A request pulse sets the bit, and the bit stays set until the CPU accepts that interrupt or software clears it. Two low-numbered latches are non-maskable. Every other latch is gated by a master enable and its own enable bit, and one of them also needs an extra enable bit. A single latch is shared by two request inputs, and a select bit decides which one feeds it.

Among the pending, enabled latches, the one with the lowest index wins and its vector goes to the CPU. Two direct exception inputs, software interrupt and undefined instruction, have no latch at all. While either one is high, it takes over the request with a shared vector. When the CPU raises its accept strobe, the winning latch clears. If the winner was maskable, the controller also sends a strobe so that the external master enable is cleared, and nesting then only happens when software enables it again. A byte-wide bus port reads the pending bits and can clear them selectively. It can never set them.

Top module: `ic_vec_ctrl`

## Requirements
- R1: After reset every pending bit is 0, irq_o is 0, and both status bytes read 0x00.
- R2: A high request bit n (2..15) sets pending bit n at the next clock edge. Latch positions 0 and 1 do not exist and always read 0.
- R3: Pending bit 11 takes req_i[11] when shared_sel_i is 0 and shared_alt_i when shared_sel_i is 1. The input that is not selected has no effect.
- R4: A maskable latch n (4..15) takes part only when imf_i and ef_i[n] are both 1. Latch 4 also needs int0_en_i. A masked bit stays pending and visible in status.
- R5: Latches 2 and 3 request regardless of imf_i and ef_i.
- R6: When several enabled latches are pending, the lowest index wins.
- R7: For a latch winner, vec_o = 0xFFFE - 2*n, so latch 2 gives 0xFFFA, latch 3 gives 0xFFF8, and latch 15 gives 0xFFE0. While swi_i or undef_i is high, irq_o is 1 and vec_o is 0xFFFC, ahead of every latch.
- R8: ack_i in a cycle where a latch wins clears that latch at the next edge and leaves the other bits alone. An ack during a direct request clears nothing.
- R9: imf_clr_o is high in the ack cycle exactly when the winner is a maskable latch. It is 0 for latches 2 and 3 and for direct requests.
- R10: A write with bus_addr_i 0 covers bits 7:0 and a write with bus_addr_i 1 covers bits 15:8. A written 0 clears a bit, a written 1 leaves it as it is, and no write can set a bit.
- R11: bus_rdata_o combinationally shows bits 7:0 when bus_addr_i is 0 and bits 15:8 when bus_addr_i is 1.
- R12: If a request and a clear (software write or ack) hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 16 | Request pulses, bit n feeds latch n (bits 0,1 unused) |
| shared_alt_i | input | 1 | Alternate request for shared latch 11 |
| shared_sel_i | input | 1 | Selects the shared latch 11 input (1 = alternate) |
| swi_i | input | 1 | Software interrupt, direct, no latch |
| undef_i | input | 1 | Undefined instruction, direct, no latch |
| imf_i | input | 1 | Master enable for maskable latches |
| ef_i | input | 16 | Per-latch enables (bits 4..15 used) |
| int0_en_i | input | 1 | Extra enable for latch 4 |
| ack_i | input | 1 | CPU accept strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the current winner |
| imf_clr_o | output | 1 | Strobe that clears the external master enable |
| bus_addr_i | input | 1 | Status byte select |
| bus_wr_i | input | 1 | Write strobe (clear-only) |
| bus_wdata_i | input | 8 | Write data, 0 bits clear |
| bus_rdata_o | output | 8 | Status read data |

## Verification
The bench goes after cases where a request and a clear collide. If the design let the clear win, an event that arrived in that cycle would be lost. Acks during a direct exception are also exercised: a controller that cleared the latch winner here would drop a pending non-maskable interrupt. The bench drives the unselected input of the shared latch and writes all ones to the status bytes. A design with a leaky multiplexer, or with a write path that can set bits, would show pending bits that should not be there. Stacked requests check that the lowest index wins. The extra gate on latch 4 and the imf_clr_o strobe are also checked, because an error in either one raises interrupts in the wrong order, when masked, or leaves nesting enabled.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned NUM_LAT    = 16;
  localparam int unsigned FIRST_LAT  = 2;
  localparam int unsigned NMI_LAST   = 3;
  localparam int unsigned INT0_IDX   = 4;
  localparam int unsigned SHARED_IDX = 11;
  localparam int unsigned VEC_W      = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam logic [VEC_W-1:0] VEC_TOP    = 16'hFFFE;
  localparam logic [VEC_W-1:0] VEC_DIRECT = 16'hFFFC;
endpackage

// File: rtl/ic_latch_bank.sv
module ic_latch_bank #(
  parameter int unsigned N     = 16,
  parameter int unsigned FIRST = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    if (g < FIRST) begin : g_none
      assign pend_o[g] = 1'b0;
    end else begin : g_lat
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[g]) q <= 1'b1;   // set beats clear
        else if (clr_i[g]) q <= 1'b0;
      end
      assign pend_o[g] = q;
    end
  end
endmodule

// File: rtl/ic_prio_enc.sv
module ic_prio_enc #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ic_vec_ctrl.sv
module ic_vec_ctrl
  import ic_pkg::*;
#(
  parameter int unsigned N_LAT  = NUM_LAT,
  localparam int unsigned NBYTE  = N_LAT / BYTE_W,
  localparam int unsigned ADDR_W = $clog2(NBYTE),
  localparam int unsigned IDX_W  = $clog2(N_LAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LAT-1:0]  req_i,
  input  logic              shared_alt_i,
  input  logic              shared_sel_i,
  input  logic              swi_i,
  input  logic              undef_i,
  input  logic              imf_i,
  input  logic [N_LAT-1:0]  ef_i,
  input  logic              int0_en_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              imf_clr_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o
);
  logic [N_LAT-1:0] eff_req, lat_en, pend_q, live, sw_clr, ack_clr;
  logic             lat_valid, direct_req;
  logic [IDX_W-1:0] win_idx;
  logic [VEC_W-1:0] vec_lat;

  for (genvar g = 0; g < N_LAT; g++) begin : g_src
    if (g < FIRST_LAT) begin : g_none
      assign eff_req[g] = 1'b0;
      assign lat_en[g]  = 1'b0;
    end else begin : g_src_on
      if (g == SHARED_IDX) begin : g_shared
        assign eff_req[g] = shared_sel_i ? shared_alt_i : req_i[g];
      end else begin : g_plain
        assign eff_req[g] = req_i[g];
      end
      if (g <= NMI_LAST) begin : g_nmi
        assign lat_en[g] = 1'b1;
      end else if (g == INT0_IDX) begin : g_int0
        assign lat_en[g] = imf_i & ef_i[g] & int0_en_i;
      end else begin : g_mask
        assign lat_en[g] = imf_i & ef_i[g];
      end
    end
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign sw_clr[b*BYTE_W +: BYTE_W] =
      (bus_wr_i && bus_addr_i == ADDR_W'(b)) ? ~bus_wdata_i : '0;
  end

  assign direct_req = swi_i | undef_i;
  assign live       = pend_q & lat_en;

  ic_prio_enc #(.N(N_LAT)) u_enc (
    .req_i  (live),
    .valid_o(lat_valid),
    .idx_o  (win_idx)
  );

  always_comb begin
    ack_clr = '0;
    if (ack_i && lat_valid && !direct_req) ack_clr[win_idx] = 1'b1;
  end

  ic_latch_bank #(.N(N_LAT), .FIRST(FIRST_LAT)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (eff_req),
    .clr_i (sw_clr | ack_clr),
    .pend_o(pend_q)
  );

  assign vec_lat     = VEC_TOP - VEC_W'({win_idx, 1'b0});
  assign irq_o       = direct_req | lat_valid;
  assign vec_o       = direct_req ? VEC_DIRECT : vec_lat;
  assign imf_clr_o   = ack_i && lat_valid && !direct_req && (win_idx > IDX_W'(NMI_LAST));
  assign bus_rdata_o = pend_q[bus_addr_i*BYTE_W +: BYTE_W];
endmodule

// File: rtl/ic_vec_ctrl_chk.sv
module ic_vec_ctrl_chk #(
  parameter int unsigned N_LAT = 16,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_LAT-1:0] pend_q,
  input logic [N_LAT-1:0] eff_req,
  input logic             ack_i,
  input logic             lat_valid,
  input logic             direct_req,
  input logic [IDX_W-1:0] win_idx,
  input logic             irq_o,
  input logic [15:0]      vec_o,
  input logic             imf_clr_o,
  input logic             imf_i
);
  localparam logic [15:0] VEC_LOW = 16'hFFFE - 16'(2 * (N_LAT - 1));

  a_r2_req_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_req != '0) |=> ((pend_q & $past(eff_req)) == $past(eff_req)));

  a_r10_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_req == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && lat_valid && !direct_req && !eff_req[win_idx]) |=> !pend_q[$past(win_idx)]);

  a_r7_vec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !direct_req) |-> (!vec_o[0] && vec_o >= VEC_LOW && vec_o <= 16'hFFFA));

  a_r9_imf_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imf_clr_o |-> (ack_i && imf_i && !direct_req));

  a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imf_i && !direct_req && pend_q[3:2] == 2'b00) |-> !irq_o);
endmodule

bind ic_vec_ctrl ic_vec_ctrl_chk #(.N_LAT(N_LAT), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pend_q    (pend_q),
  .eff_req   (eff_req),
  .ack_i     (ack_i),
  .lat_valid (lat_valid),
  .direct_req(direct_req),
  .win_idx   (win_idx),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .imf_clr_o (imf_clr_o),
  .imf_i     (imf_i)
);

// File: tb/ic_vec_ctrl_tb.sv
`timescale 1ns/1ps
module ic_vec_ctrl_tb;
  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] req_i = '0, ef_i = '0;
  logic        shared_alt_i = 0, shared_sel_i = 0, swi_i = 0, undef_i = 0;
  logic        imf_i = 0, int0_en_i = 0, ack_i = 0;
  logic        irq_o, imf_clr_o, bus_wr_i = 0;
  logic [15:0] vec_o;
  logic        bus_addr_i = 0;
  logic [7:0]  bus_wdata_i = '0, bus_rdata_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ic_vec_ctrl u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic pulse(logic [15:0] m);
    req_i = m; step(); req_i = '0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    bus_addr_i = a; #0.5; d = bus_rdata_o;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1; step(); bus_wr_i = 0;
  endtask

  task automatic clear_all();
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", irq_o, 0);
    rd(0, d); chk("R1 lo", d, 0);
    rd(1, d); chk("R1 hi", d, 0);
  endtask

  task automatic t_set_mask_clear();
    logic [7:0] d;
    pulse(16'h0023);
    rd(0, d); chk("R2 set bit5, bits0/1 absent", d, 8'h20);
    chk("R4 masked no irq", irq_o, 0);
    ef_i[5] = 1; #0.5; chk("R4 imf off", irq_o, 0);
    imf_i = 1; #0.5;
    chk("R4 enabled irq", irq_o, 1);
    chk("R7 vec5", vec_o, 16'hFFF4);
    wr(0, 8'hDF);
    rd(0, d); chk("R10 clear bit5", d, 0);
    wr(0, 8'hFF); wr(1, 8'hFF);
    rd(0, d); chk("R10 no set lo", d, 0);
    rd(1, d); chk("R10 no set hi", d, 0);
    imf_i = 0; ef_i = '0;
  endtask

  task automatic t_int0();
    pulse(16'h0010);
    imf_i = 1; ef_i[4] = 1; #0.5;
    chk("R4 int0 gate", irq_o, 0);
    int0_en_i = 1; #0.5;
    chk("R4 int0 irq", irq_o, 1);
    chk("R7 vec4", vec_o, 16'hFFF6);
    clear_all(); imf_i = 0; ef_i = '0; int0_en_i = 0;
  endtask

  task automatic t_nmi();
    logic [7:0] d;
    pulse(16'h0008);
    chk("R5 nmi irq", irq_o, 1);
    chk("R7 vec3", vec_o, 16'hFFF8);
    pulse(16'h0004);
    chk("R6 vec2 wins", vec_o, 16'hFFFA);
    ack_i = 1; #0.5;
    chk("R9 no imf_clr nmi", imf_clr_o, 0);
    step(); ack_i = 0;
    rd(0, d); chk("R8 ack clears 2", d, 8'h08);
    ack_i = 1; step(); ack_i = 0;
    rd(0, d); chk("R8 ack clears 3", d, 0);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    imf_i = 1; ef_i = 16'hFFFF;
    pulse(16'hA100);
    chk("R6 bit8 wins", vec_o, 16'hFFEE);
    ack_i = 1; #0.5;
    chk("R9 imf_clr maskable", imf_clr_o, 1);
    step(); ack_i = 0;
    rd(1, d); chk("R8 only bit8 cleared", d, 8'hA0);
    chk("R6 next bit13", vec_o, 16'hFFE4);
    clear_all(); imf_i = 0; ef_i = '0;
  endtask

  task automatic t_mux();
    logic [7:0] d;
    shared_sel_i = 0; shared_alt_i = 1; step(); shared_alt_i = 0;
    rd(1, d); chk("R3 alt ignored", d, 0);
    pulse(16'h0800);
    rd(1, d); chk("R3 sel0 ext", d, 8'h08);
    clear_all();
    shared_sel_i = 1; pulse(16'h0800);
    rd(1, d); chk("R3 ext ignored", d, 0);
    shared_alt_i = 1; step(); shared_alt_i = 0;
    rd(1, d); chk("R3 sel1 alt", d, 8'h08);
    imf_i = 1; ef_i[11] = 1; #0.5;
    chk("R7 vec11", vec_o, 16'hFFE8);
    clear_all(); imf_i = 0; ef_i = '0; shared_sel_i = 0;
  endtask

  task automatic t_direct();
    logic [7:0] d;
    pulse(16'h0004);
    swi_i = 1; #0.5;
    chk("R7 swi vec", vec_o, 16'hFFFC);
    ack_i = 1; #0.5;
    chk("R9 no imf_clr direct", imf_clr_o, 0);
    step(); ack_i = 0; swi_i = 0;
    rd(0, d); chk("R8 direct ack keeps latch", d, 8'h04);
    undef_i = 1; #0.5;
    chk("R7 undef vec", vec_o, 16'hFFFC);
    undef_i = 0; clear_all();
  endtask

  task automatic t_race();
    logic [7:0] d;
    bus_addr_i = 0; bus_wdata_i = 8'h00; bus_wr_i = 1; req_i = 16'h0040;
    step(); bus_wr_i = 0; req_i = '0;
    rd(0, d); chk("R12 set beats sw clear", d, 8'h40);
    imf_i = 1; ef_i[6] = 1; ack_i = 1; req_i = 16'h0040;
    step(); ack_i = 0; req_i = '0;
    rd(0, d); chk("R12 set beats ack", d, 8'h40);
    clear_all(); imf_i = 0; ef_i = '0;
    rd(0, d); chk("R11 lo after clear", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1; #0.5;
    t_reset();
    t_set_mask_clear();
    t_int0();
    t_nmi();
    t_prio();
    t_mux();
    t_direct();
    t_race();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule